// File: doc/BRIEF.md
# Min-of-Max 2x2 Pixel Decimator

This block shrinks luma pixel data to a quarter of its area so that a coarse motion search can work on fewer points. Every non-overlapping 2x2 group of unsigned 8-bit pixels becomes one output sample. Within a group, the block first takes the larger of the two pixels in each source column. The output sample is the smaller of those two column maxima. Compared with averaging, this kernel keeps edge strength. Compared with plain subsampling, it does not depend on which pixel happens to sit at the group origin.

The input side takes a vertical slice two source columns wide and one full block tall (16 rows by default) on every cycle where the valid strobe is high. From that slice the block produces one decimated column of 8 samples. The column appears on the output one clock later, together with its column index and an end-of-block flag. In the same clock edge, the column is written into a column-ordered current-block register file of 8 columns by 8 rows. Columns are filled left to right, so a complete 16x16 macroblock is loaded in 8 valid cycles. The stored contents stay unchanged until the next macroblock starts overwriting them.

Top module: `quad_minmax_decim`

## Requirements
- R1: For output row k of a column, the sample equals min(max(L[2k], L[2k+1]), max(R[2k], R[2k+1])). L and R are the left and right input columns, and row r of a column sits in bits [8r+7:8r].
- R2: `out_valid` is high in exactly those cycles that follow a clock edge at which `in_valid` was high, giving one cycle of latency.
- R3: While `rst` is high at a clock edge, the following are all cleared at that edge: `out_valid`, `out_last`, `out_col_idx`, the internal column counter and every bit of `blk_store`.
- R4: Successive valid inputs are written to columns 0, 1, …, 7 in that order. `out_col_idx` shows the index of the column just written.
- R5: `out_last` is high only together with the write of column 7. The write that follows it starts again at column 0.
- R6: A cycle without `in_valid` changes no bit of `blk_store`. A write changes only its own column.
- R7: Comparisons are unsigned, so pixel values 0, 127, 128 and 255 order as plain binary numbers.
- R8: After eight consecutive writes, `blk_store` holds the full 8x8 decimation of the 16x16 input block. Column c, row r is at bits [8(8c+r)+7 : 8(8c+r)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input slice strobe |
| in_left | input | 128 | Left source column, 16 rows of 8 bits, row 0 in the low byte |
| in_right | input | 128 | Right source column, same layout |
| out_valid | output | 1 | Decimated column valid |
| out_col | output | 64 | Decimated column, 8 samples, row 0 in the low byte |
| out_col_idx | output | 3 | Index of the column just written |
| out_last | output | 1 | High with the eighth column of a block |
| blk_store | output | 512 | Current-block register file, column-ordered |

## Verification
The assertions check on every cycle that valid follows the strobe by one clock, that the end flag appears only with column 7, that the column index advances and wraps, that the store holds still on idle cycles, and that each sample is one of its four source pixels and no greater than the largest of them. The exact min-of-max value of each sample under unsigned ordering, the full block contents after a load, and the effect of reset in the middle of a block can only be shown by the bench. To show them, the bench sweeps every combination of six boundary values (0, 1, 127, 128, 254, 255) over the four pixel positions and then runs random blocks.

// File: rtl/decim_pkg.sv
package decim_pkg;
    localparam int DEF_PW    = 8;
    localparam int DEF_OROWS = 8;
    localparam int DEF_OCOLS = 8;
endpackage

// File: rtl/decim_kernel.sv
module decim_kernel #(
    parameter int PW = decim_pkg::DEF_PW
) (
    input  logic [PW-1:0] tl,
    input  logic [PW-1:0] bl,
    input  logic [PW-1:0] tr,
    input  logic [PW-1:0] br,
    output logic [PW-1:0] y
);
    logic [PW-1:0] max_l, max_r;

    always_comb begin
        max_l = (tl > bl) ? tl : bl;
        max_r = (tr > br) ? tr : br;
        y     = (max_l < max_r) ? max_l : max_r;
    end

    // R1: result is one of the four source pixels and never above all of them
    always_comb begin
        a_r1_pick_source: assert ((y == tl) || (y == bl) || (y == tr) || (y == br));
        a_r7_not_above_all: assert ((y <= tl) || (y <= bl) || (y <= tr) || (y <= br));
    end
endmodule

// File: rtl/decim_colstore.sv
module decim_colstore #(
    parameter int PW    = decim_pkg::DEF_PW,
    parameter int OROWS = decim_pkg::DEF_OROWS,
    parameter int OCOLS = decim_pkg::DEF_OCOLS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(OCOLS)-1:0]      wr_sel,
    input  logic [OROWS*PW-1:0]           wr_col,
    output logic [OCOLS*OROWS*PW-1:0]     store
);
    localparam int CW = OROWS*PW;

    logic [CW-1:0] mem_d [OCOLS];
    logic [CW-1:0] mem_q [OCOLS];

    always_comb begin
        for (int c = 0; c < OCOLS; c++) mem_d[c] = mem_q[c];
        if (wr_en) mem_d[wr_sel] = wr_col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < OCOLS; c++) mem_q[c] <= '0;
        end else begin
            for (int c = 0; c < OCOLS; c++) mem_q[c] <= mem_d[c];
        end
    end

    for (genvar c = 0; c < OCOLS; c++) begin : g_flat
        assign store[c*CW +: CW] = mem_q[c];
    end

    // R6: idle cycles leave the register file untouched
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(store));
endmodule

// File: rtl/quad_minmax_decim.sv
module quad_minmax_decim #(
    parameter int PW    = decim_pkg::DEF_PW,
    parameter int OROWS = decim_pkg::DEF_OROWS,
    parameter int OCOLS = decim_pkg::DEF_OCOLS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [2*OROWS*PW-1:0]         in_left,
    input  logic [2*OROWS*PW-1:0]         in_right,
    output logic                          out_valid,
    output logic [OROWS*PW-1:0]           out_col,
    output logic [$clog2(OCOLS)-1:0]      out_col_idx,
    output logic                          out_last,
    output logic [OCOLS*OROWS*PW-1:0]     blk_store
);
    localparam int IDXW = $clog2(OCOLS);
    localparam int CW   = OROWS*PW;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(OCOLS-1);

    typedef struct packed {
        logic            vld;
        logic            last;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] cnt;
        logic [CW-1:0]   col;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] dec_col;

    for (genvar k = 0; k < OROWS; k++) begin : g_kern
        decim_kernel #(.PW(PW)) u_kern (
            .tl (in_left [(2*k)*PW   +: PW]),
            .bl (in_left [(2*k+1)*PW +: PW]),
            .tr (in_right[(2*k)*PW   +: PW]),
            .br (in_right[(2*k+1)*PW +: PW]),
            .y  (dec_col[k*PW +: PW])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.last = 1'b0;
        if (in_valid) begin
            st_d.col  = dec_col;
            st_d.idx  = st_q.cnt;
            st_d.last = (st_q.cnt == LAST_IDX);
            st_d.cnt  = (st_q.cnt == LAST_IDX) ? '0 : st_q.cnt + IDXW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    decim_colstore #(.PW(PW), .OROWS(OROWS), .OCOLS(OCOLS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (in_valid),
        .wr_sel (st_q.cnt),
        .wr_col (dec_col),
        .store  (blk_store)
    );

    assign out_valid   = st_q.vld;
    assign out_col     = st_q.col;
    assign out_col_idx = st_q.idx;
    assign out_last    = st_q.last;

    // R2: one cycle of latency from strobe to valid
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R5: end flag only with the last column
    a_r5_last_col: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && out_col_idx == LAST_IDX));
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (out_last && in_valid) |=> (out_col_idx == '0));
    // R4: columns advance in order
    a_r4_advance: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last && in_valid) |=> (out_col_idx == $past(out_col_idx) + IDXW'(1)));
endmodule

// File: tb/sim_quad_minmax_decim.sv
module sim_quad_minmax_decim;
    localparam int PW = 8, OR = 8, OC = 8, CW = OR*PW;

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic [2*CW-1:0] in_left = '0, in_right = '0;
    logic out_valid, out_last;
    logic [CW-1:0] out_col;
    logic [2:0] out_col_idx;
    logic [OC*CW-1:0] blk_store;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [CW-1:0] exp_store [OC];
    int exp_idx = 0;

    always #5 clk = ~clk;

    quad_minmax_decim u0 (.clk, .rst, .in_valid, .in_left, .in_right,
        .out_valid, .out_col, .out_col_idx, .out_last, .blk_store);

    function automatic logic [7:0] mx(logic [7:0] a, logic [7:0] b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [7:0] mn(logic [7:0] a, logic [7:0] b);
        return (a < b) ? a : b;
    endfunction
    function automatic logic [CW-1:0] model(logic [2*CW-1:0] l, logic [2*CW-1:0] r);
        logic [CW-1:0] v;
        for (int k = 0; k < OR; k++)
            v[k*8 +: 8] = mn(mx(l[16*k +: 8], l[16*k+8 +: 8]), mx(r[16*k +: 8], r[16*k+8 +: 8]));
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [OC*CW-1:0] act, logic [OC*CW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_store(string req);
        logic [OC*CW-1:0] e;
        for (int c = 0; c < OC; c++) e[c*CW +: CW] = exp_store[c];
        chk(blk_store == e, req, blk_store, e);
    endtask

    task automatic push(logic [2*CW-1:0] l, logic [2*CW-1:0] r);
        logic [CW-1:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        e = model(l, r);
        @(posedge clk); #1;
        chk(out_valid === 1'b1, "R2", out_valid, 1);
        chk(out_col === e, "R1/R7", out_col, e);
        chk(out_col_idx == 3'(exp_idx), "R4", out_col_idx, exp_idx);
        chk(out_last == (exp_idx == OC-1), "R5", out_last, exp_idx == OC-1);
        exp_store[exp_idx] = e;
        check_store("R6/R8");
        exp_idx = (exp_idx + 1) % OC;
    endtask

    task automatic idle(int n);
        @(negedge clk); in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            chk(out_valid === 1'b0, "R2 idle", out_valid, 0);
            check_store("R6 idle");
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        for (int c = 0; c < OC; c++) exp_store[c] = '0;
        exp_idx = 0;
        chk(out_valid == 0 && out_last == 0 && out_col_idx == 0, "R3", {out_valid, out_last, out_col_idx}, 0);
        check_store("R3 store");
    endtask

    initial begin
        logic [7:0] vals [6];
        logic [2*CW-1:0] l, r;
        int g;
        vals = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd254, 8'd255};
        do_reset();
        // R1 R7: full sweep of boundary values over four positions
        g = 0; l = '0; r = '0;
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                    for (int d = 0; d < 6; d++) begin
                        l[16*g +: 8] = vals[a]; l[16*g+8 +: 8] = vals[b];
                        r[16*g +: 8] = vals[c]; r[16*g+8 +: 8] = vals[d];
                        g++;
                        if (g == OR) begin push(l, r); g = 0; end
                    end
        idle(3);
        // R8: random full blocks, with idle gaps inside one block (R6)
        for (int blk = 0; blk < 6; blk++) begin
            for (int c = 0; c < OC; c++) begin
                for (int w = 0; w < 2*CW/32; w++) begin
                    l[w*32 +: 32] = $urandom;
                    r[w*32 +: 32] = $urandom;
                end
                push(l, r);
                if (c == 3 && blk == 2) idle(2);
            end
        end
        // R3: reset in the middle of a block, then restart at column 0 (R4)
        push('1, '0); push('0, '1); push({16{8'h80, 8'h7f}}, {16{8'h01, 8'hfe}});
        do_reset();
        push({16{8'hff}}, {16{8'h00}});
        idle(1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); rst = 1'b0;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule